// File: doc/BRIEF.md
# Lossless Stall-Go Link Controller

This block sits between the input ports of a packet router and its scheduler, with one small controller per outgoing link. Each controller watches two signals from its link. One is an almost-full flag from the receiving buffer downstream. The other is a strobe that pulses in every cycle in which a flit leaves on that link. From these it tells the scheduler, in the same cycle, whether the link may carry another flit.

When the receiver is close to full, the controller withholds permission. The sender then waits until space returns instead of pushing a flit that the receiver would discard. Congestion therefore costs cycles and never costs data. Each controller is a three-state Mealy machine with the states Go, Sent and Stop. Its permission output comes from the state it is about to enter, which is a function of the current inputs.

The number of links is a parameter. The controllers are independent copies.

Top module: `sg_link_ctrl`

## Requirements
- R1: After reset, and in the first cycle after reset is released, every lane's state field reads Go, encoded 2'b00.
- R2: When a lane's almost-full input is 1, that lane's permission output is 0 in the same cycle, whatever its sent strobe is.
- R3: When a lane's almost-full input is 1 at a clock edge, the lane's state field reads Stop (2'b10) after that edge.
- R4: When almost-full is 0 and the sent strobe is 1, permission is 1 in the same cycle, and after the edge the state field reads Sent (2'b01).
- R5: When almost-full is 0 and the sent strobe is 0, permission is 1 in the same cycle, and after the edge the state field reads Go (2'b00).
- R6: A lane in Stop stays in Stop for as long as its almost-full input stays 1. It leaves Stop only at an edge where almost-full is 0.
- R7: Lanes are independent. Lane i uses bit i of each input and of the permission output, and bits [2i+1:2i] of the state output. Inputs on one lane never change another lane's outputs.
- R8: Suppose a sender transmits only while permission is 1, and the receiving buffer of depth D raises almost-full whenever it holds D-1 or more flits. Then the buffer never holds more than D flits, so no flit is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nearly_full_i | input | LANES | Almost-full flag from each lane's downstream buffer |
| data_sent_i | input | LANES | Pulses in each cycle in which the lane transmits a flit |
| go_o | output | LANES | Permission to transmit on each lane (1 = may send) |
| state_o | output | 2*LANES | State of each lane's controller (00 Go, 01 Sent, 10 Stop) |

## Verification
The assertions assume nothing about how the sent strobe relates to permission. A state check only needs the inputs to be stable at the clock edge, and the bench meets that by driving at the falling edge.

The exhaustive sweep deliberately drives every combination of almost-full and sent from every state, including a strobe while permission is low. The lossless property R8 depends on an input assumption: the sender must obey the permission output. The random traffic phase is built to respect that. It raises a send only after it has read permission in that cycle, and it derives almost-full from its own buffer occupancy, plus random extra stalls.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_GO   = 2'b00,
        ST_SENT = 2'b01,
        ST_STOP = 2'b10
    } sg_state_e;

    typedef struct packed {
        sg_state_e state;
    } sg_lane_regs_t;
endpackage

// File: rtl/sg_lane.sv
module sg_lane
    import sg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nearly_full,
    input  logic                data_sent,
    output logic                go,
    output logic [STATE_W-1:0]  state
);
    sg_lane_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (nearly_full) begin
            regs_d.state = ST_STOP;
        end else if (data_sent) begin
            regs_d.state = ST_SENT;
        end else begin
            regs_d.state = ST_GO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_GO};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Mealy output: permission follows the state being entered
    assign go    = (regs_d.state != ST_STOP);
    assign state = regs_q.state;

    assert_reset_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> regs_q.state == ST_GO);

    assert_nogo_then_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> regs_q.state == ST_STOP);

    assert_full_to_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nearly_full |=> regs_q.state == ST_STOP);

    assert_sent_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nearly_full && data_sent) |=> (regs_q.state == ST_SENT));

    assert_idle_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nearly_full && !data_sent) |=> (regs_q.state == ST_GO));

    assert_leave_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_STOP && nearly_full) |=> regs_q.state == ST_STOP);
endmodule

// File: rtl/sg_link_ctrl.sv
module sg_link_ctrl
    import sg_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         nearly_full_i,
    input  logic [LANES-1:0]         data_sent_i,
    output logic [LANES-1:0]         go_o,
    output logic [STATE_W*LANES-1:0] state_o
);
    localparam int SW_TOTAL = STATE_W * LANES;

    logic [SW_TOTAL-1:0] state_flat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sg_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .nearly_full (nearly_full_i[g]),
            .data_sent   (data_sent_i[g]),
            .go          (go_o[g]),
            .state       (state_flat[g*STATE_W +: STATE_W])
        );
    end

    assign state_o = state_flat;

    // R7: each lane's permission is tied to its own flag only
    assert_lane_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[1:0] == ST_STOP && !nearly_full_i[0]) |-> go_o[0]);
endmodule

// File: tb/sg_link_ctrl_bench.sv
module sg_link_ctrl_bench;
    localparam int LANES = 2;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0]   nf = '0;
    logic [LANES-1:0]   ds = '0;
    logic [LANES-1:0]   go;
    logic [2*LANES-1:0] st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sg_link_ctrl #(.LANES(LANES)) u_sg_link_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .nearly_full_i (nf),
        .data_sent_i   (ds),
        .go_o          (go),
        .state_o       (st)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_state(input bit f, input bit s);
        return f ? 2 : (s ? 1 : 0);
    endfunction

    // drive at falling edge, check permission, then state after rising edge
    task automatic step(input logic [LANES-1:0] f, input logic [LANES-1:0] s, input bit verify);
        @(negedge clk);
        nf = f; ds = s;
        #0.5;
        if (verify) begin
            for (int l = 0; l < LANES; l++) begin
                chk(f[l] ? "R2 go low on full" : (s[l] ? "R4 go with send" : "R5 go idle"),
                    int'(go[l]), f[l] ? 0 : 1);
            end
        end
        @(posedge clk);
        #0.5;
        if (verify) begin
            for (int l = 0; l < LANES; l++) begin
                chk(f[l] ? "R3 enter stop" : (s[l] ? "R4 enter sent" : "R5 enter go"),
                    int'(st[2*l +: 2]), exp_state(f[l], s[l]));
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int cnt [LANES];
        repeat (3) @(posedge clk);
        #0.5;
        chk("R1 state in reset", int'(st), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #0.5;
        chk("R1 state after release", int'(st), 0);
        chk("R1 go after release", int'(go), 3);

        // exhaustive: every prior state x every input pair; lane 1 gets the inverse (R7)
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 4; c++) begin
                bit pf = (p == 2);
                bit ps = (p == 1);
                bit f = c[1];
                bit s = c[0];
                step({~pf, pf}, {~ps, ps}, 1'b0);
                step({~f, f}, {~s, s}, 1'b1);
            end
        end

        // R6: hold full on lane 0, toggle send; stays in stop
        for (int k = 0; k < 6; k++) begin
            step(2'b01, k[0] ? 2'b11 : 2'b00, 1'b0);
            chk("R6 stop held", int'(st[1:0]), 2);
            chk("R7 lane1 unaffected", int'(st[3:2]), k[0] ? 1 : 0);
        end
        step(2'b00, 2'b00, 1'b0);
        chk("R6 leaves stop", int'(st[1:0]), 0);

        // R8: random traffic against a modelled buffer
        for (int l = 0; l < LANES; l++) cnt[l] = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            logic [LANES-1:0] f, s;
            @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                f[l] = (cnt[l] >= DEPTH - 1) || ($urandom_range(0, 5) == 0);
            end
            nf = f; ds = '0;
            #0.5;
            for (int l = 0; l < LANES; l++) s[l] = go[l] && ($urandom_range(0, 3) != 0);
            ds = s;
            @(posedge clk);
            for (int l = 0; l < LANES; l++) begin
                bit pop = (cnt[l] > 0) && ($urandom_range(0, 2) == 0);
                cnt[l] = cnt[l] + int'(s[l]) - int'(pop);
                if (cnt[l] > DEPTH) chk("R8 buffer overflow", cnt[l], DEPTH);
                else checks++;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule